// File: doc/BRIEF.md
# Page-Table Entry Accessed/Dirty Updater

This block sits beside a page-table walker. It keeps the accessed (A) and dirty (D) bits of leaf page-table entries up to date. For each translation the walker hands over the leaf entry it read, the entry's physical address, the kind of access (load, store or instruction fetch) and a flag that marks the access as speculative. The block first checks that the entry is well formed and grants the access. It then either lets the access go at once, reports a page fault, or sets the missing bits with an atomic compare-and-swap on a simple memory port. The load/store unit learns through a one-cycle response when the access may go ahead.

A static configuration input picks one scheme for all requests. In the fault scheme a missing bit is handed back to software as a page fault. In the update scheme the hardware sets the missing bit. A compare-and-swap that finds the entry changed returns the current value. The block checks that value again, and it either faults without writing or tries again with the fresh value, for a bounded number of attempts.

D is written only for a committed store. A speculative store that needs D waits for a commit strobe. A may be set while the access is still speculative. A flush that arrives after the entry has been written leaves the bits set and drops the access.

Top module: `pte_ad_updater`

## Requirements
- R1: When the entry passes the leaf check, A is set, and the access is not a store or D is already set, the block answers with `rsp_kind` 0 (release) in the same cycle as `req_valid`. It issues no memory request.
- R2: The entry bits are V=0, R=1, W=2, X=3, A=6 and D=7. The `req_acc` codes are 0 load, 1 store, 2 fetch and 3 reserved. An entry fails the check if V is clear, if W is set without R, or if neither R nor X is set. The access also fails if a load lacks R (X is enough when `cfg_exec_readable` is 1), if a store lacks W, if a fetch lacks X, or if the code is 3. A failed check gives `rsp_kind` 1 (fault) and no memory request.
- R3: With `cfg_hw_update` at 0, an access that finds A clear, or a store that finds D clear, gets a fault and causes no memory request.
- R4: With `cfg_hw_update` at 1, the block issues a compare-and-swap. The compare value is the walker's entry. The new value is that entry with A set, and with D also set for a store.
- R5: A load or fetch never sets D.
- R6: A release that follows a compare-and-swap comes only after the memory response has returned the expected old value.
- R7: When a compare-and-swap returns a different value, the block checks that value again. If it now fails the check, the block faults without another write. If it passes, the next compare-and-swap uses the returned value as its compare value.
- R8: After `MAX_RETRY` mismatching compare-and-swap responses for one request, the block answers `rsp_kind` 2 (retry).
- R9: A speculative store that needs D issues no memory request until `commit` is pulsed. A speculative access that needs only A goes ahead without a commit.
- R10: A `squash` received after acceptance and before the response gives `rsp_kind` 3 (drop). If a write was already issued, it completes and its bits stay in memory.
- R11: `req_ready` is high only while idle, and the block handles one request at a time. `mem_req_valid` stays high with stable address and data until `mem_req_ready`.
- R12: Every response other than an immediate release is a single-cycle `rsp_valid` pulse, followed by `req_ready` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hw_update | input | 1 | 1 selects the hardware update scheme, 0 the fault scheme |
| cfg_exec_readable | input | 1 | Lets loads use execute-only pages |
| req_valid | input | 1 | Walker request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_pte | input | 64 | Leaf entry as seen by the walker |
| req_paddr | input | PA_W | Physical address of the leaf entry |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_spec | input | 1 | Access is still speculative |
| commit | input | 1 | Pulse: the pending access is now non-speculative |
| squash | input | 1 | Pulse: the pending access was flushed |
| rsp_valid | output | 1 | Response strobe |
| rsp_kind | output | 2 | 0 release, 1 fault, 2 retry, 3 drop |
| mem_req_valid | output | 1 | Compare-and-swap request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | PA_W | Entry address |
| mem_req_cmp | output | 64 | Expected old value |
| mem_req_wdata | output | 64 | Value written on a match |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_rdata | input | 64 | Old value found in memory |

## Verification
The bench changes the memory copy of the entry between the walker's read and the compare-and-swap. In one case the entry becomes invalid; a design that trusted the walker's copy would write A into an entry that is no longer valid, or would release the access anyway. In another case the entry only picks up an unrelated bit; a design that did not adopt the returned value would spin until it gave a retry instead of a release. A model that keeps flipping the entry drives the retry limit, and a design with an off-by-one counter issues the wrong number of attempts. The speculative-store and squash cases catch a design that writes D before commit, that reports release for a flushed access, or that releases before the memory acknowledge.

// File: rtl/ptead_pkg.sv
package ptead_pkg;

    localparam int PTE_W = 64;
    typedef logic [PTE_W-1:0] pte_t;

    localparam int BIT_V = 0;
    localparam int BIT_R = 1;
    localparam int BIT_W = 2;
    localparam int BIT_X = 3;
    localparam int BIT_A = 6;
    localparam int BIT_D = 7;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RSP_RELEASE = 2'd0,
        RSP_FAULT   = 2'd1,
        RSP_RETRY   = 2'd2,
        RSP_DROP    = 2'd3
    } rsp_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WAIT_COMMIT,
        ST_CAS_REQ,
        ST_CAS_RESP,
        ST_RELEASE,
        ST_FAULT,
        ST_RETRY,
        ST_DROP
    } state_e;

    // Outcome of the leaf check on one entry for one access kind.
    typedef struct packed {
        logic legal;
        logic need_a;
        logic need_d;
    } verdict_t;

    function automatic logic entry_well_formed(pte_t e);
        return e[BIT_V] && !(e[BIT_W] && !e[BIT_R]) && (e[BIT_R] || e[BIT_X]);
    endfunction

    function automatic pte_t merge_ad(pte_t e, verdict_t v);
        pte_t r;
        r = e;
        r[BIT_A] = 1'b1;
        if (v.need_d) begin
            r[BIT_D] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/ptead_perm_chk.sv
module ptead_perm_chk
    import ptead_pkg::*;
(
    input  pte_t     pte,
    input  acc_e     acc,
    input  logic     exec_readable,
    output verdict_t verdict
);

    logic grant;

    always_comb begin
        case (acc)
            ACC_LOAD:  grant = pte[BIT_R] || (exec_readable && pte[BIT_X]);
            ACC_STORE: grant = pte[BIT_W];
            ACC_FETCH: grant = pte[BIT_X];
            default:   grant = 1'b0;
        endcase
        verdict.legal  = entry_well_formed(pte) && grant;
        verdict.need_a = !pte[BIT_A];
        verdict.need_d = (acc == ACC_STORE) && !pte[BIT_D];
    end

endmodule

// File: rtl/ptead_ctrl.sv
module ptead_ctrl
    import ptead_pkg::*;
#(
    parameter int PA_W      = 56,
    parameter int MAX_RETRY = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_hw_update,
    input  logic            req_valid,
    output logic            req_ready,
    input  pte_t            req_pte,
    input  logic [PA_W-1:0] req_paddr,
    input  acc_e            req_acc,
    input  logic            req_spec,
    input  logic            commit,
    input  logic            squash,
    input  verdict_t        verdict,
    output pte_t            work_pte,
    output acc_e            work_acc,
    output logic            rsp_valid,
    output rsp_e            rsp_kind,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    output pte_t            mem_req_cmp,
    output pte_t            mem_req_wdata,
    input  logic            mem_rsp_valid,
    input  pte_t            mem_rsp_rdata
);

    localparam int CNT_W = (MAX_RETRY < 2) ? 1 : $clog2(MAX_RETRY + 1);
    localparam logic [CNT_W-1:0] LAST_TRY = CNT_W'(MAX_RETRY - 1);

    state_e           state_q;
    pte_t             pte_q;
    logic [PA_W-1:0]  paddr_q;
    acc_e             acc_q;
    logic             spec_q;
    logic             squashed_q;
    logic [CNT_W-1:0] tries_q;

    logic idle;
    logic fast_ok;

    assign idle     = (state_q == ST_IDLE);
    assign fast_ok  = verdict.legal && !verdict.need_a && !verdict.need_d;
    assign work_pte = pte_q;
    assign work_acc = acc_q;

    // Response and memory-port outputs.
    always_comb begin
        req_ready = idle;
        rsp_valid = 1'b0;
        rsp_kind  = RSP_RELEASE;
        case (state_q)
            ST_IDLE: begin
                if (req_valid && fast_ok) begin
                    rsp_valid = 1'b1;
                end
            end
            ST_RELEASE: begin
                rsp_valid = 1'b1;
                rsp_kind  = squashed_q ? RSP_DROP : RSP_RELEASE;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_kind  = RSP_FAULT;
            end
            ST_RETRY: begin
                rsp_valid = 1'b1;
                rsp_kind  = RSP_RETRY;
            end
            ST_DROP: begin
                rsp_valid = 1'b1;
                rsp_kind  = RSP_DROP;
            end
            default: ;
        endcase
    end

    assign mem_req_valid = (state_q == ST_CAS_REQ);
    assign mem_req_addr  = paddr_q;
    assign mem_req_cmp   = pte_q;
    assign mem_req_wdata = merge_ad(pte_q, verdict);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            pte_q      <= '0;
            paddr_q    <= '0;
            acc_q      <= ACC_LOAD;
            spec_q     <= 1'b0;
            squashed_q <= 1'b0;
            tries_q    <= '0;
        end else begin
            if (!idle) begin
                if (commit) begin
                    spec_q <= 1'b0;
                end
                if (squash) begin
                    squashed_q <= 1'b1;
                end
            end
            case (state_q)
                ST_IDLE: begin
                    if (req_valid && !fast_ok) begin
                        pte_q      <= req_pte;
                        paddr_q    <= req_paddr;
                        acc_q      <= req_acc;
                        spec_q     <= req_spec;
                        squashed_q <= 1'b0;
                        tries_q    <= '0;
                        state_q    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (squashed_q || squash) begin
                        state_q <= ST_DROP;
                    end else if (!verdict.legal) begin
                        state_q <= ST_FAULT;
                    end else if (!verdict.need_a && !verdict.need_d) begin
                        state_q <= ST_RELEASE;
                    end else if (!cfg_hw_update) begin
                        state_q <= ST_FAULT;
                    end else if (verdict.need_d && spec_q && !commit) begin
                        state_q <= ST_WAIT_COMMIT;
                    end else begin
                        state_q <= ST_CAS_REQ;
                    end
                end
                ST_WAIT_COMMIT: begin
                    if (squash) begin
                        state_q <= ST_DROP;
                    end else if (commit) begin
                        state_q <= ST_CAS_REQ;
                    end
                end
                ST_CAS_REQ: begin
                    if (mem_req_ready) begin
                        state_q <= ST_CAS_RESP;
                    end
                end
                ST_CAS_RESP: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_rdata == pte_q) begin
                            state_q <= ST_RELEASE;
                        end else if (tries_q == LAST_TRY) begin
                            state_q <= ST_RETRY;
                        end else begin
                            tries_q <= tries_q + 1'b1;
                            pte_q   <= mem_rsp_rdata;
                            state_q <= ST_CHECK;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pte_ad_updater.sv
module pte_ad_updater
    import ptead_pkg::*;
#(
    parameter int PA_W      = 56,
    parameter int MAX_RETRY = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_hw_update,
    input  logic            cfg_exec_readable,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [63:0]     req_pte,
    input  logic [PA_W-1:0] req_paddr,
    input  logic [1:0]      req_acc,
    input  logic            req_spec,
    input  logic            commit,
    input  logic            squash,
    output logic            rsp_valid,
    output logic [1:0]      rsp_kind,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    output logic [63:0]     mem_req_cmp,
    output logic [63:0]     mem_req_wdata,
    input  logic            mem_rsp_valid,
    input  logic [63:0]     mem_rsp_rdata
);

    pte_t     work_pte;
    acc_e     work_acc;
    pte_t     chk_pte;
    acc_e     chk_acc;
    verdict_t verdict;
    rsp_e     kind;

    // While idle the check looks at the incoming entry; otherwise at the held one.
    assign chk_pte  = req_ready ? req_pte : work_pte;
    assign chk_acc  = req_ready ? acc_e'(req_acc) : work_acc;
    assign rsp_kind = kind;

    ptead_perm_chk u_perm (
        .pte           (chk_pte),
        .acc           (chk_acc),
        .exec_readable (cfg_exec_readable),
        .verdict       (verdict)
    );

    ptead_ctrl #(
        .PA_W      (PA_W),
        .MAX_RETRY (MAX_RETRY)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .cfg_hw_update (cfg_hw_update),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_pte       (req_pte),
        .req_paddr     (req_paddr),
        .req_acc       (acc_e'(req_acc)),
        .req_spec      (req_spec),
        .commit        (commit),
        .squash        (squash),
        .verdict       (verdict),
        .work_pte      (work_pte),
        .work_acc      (work_acc),
        .rsp_valid     (rsp_valid),
        .rsp_kind      (kind),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_req_cmp   (mem_req_cmp),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata)
    );

endmodule

// File: rtl/ptead_checker.sv
module ptead_checker
    import ptead_pkg::*;
#(
    parameter int PA_W = 56
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_hw_update,
    input logic            req_valid,
    input logic            req_ready,
    input logic [1:0]      req_acc,
    input logic            req_spec,
    input logic            commit,
    input logic            rsp_valid,
    input logic [1:0]      rsp_kind,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic [63:0]     mem_req_cmp,
    input logic [63:0]     mem_req_wdata,
    input logic            mem_rsp_valid
);

    localparam logic [63:0] AD_MASK = (64'd1 << BIT_A) | (64'd1 << BIT_D);

    logic       spec_track;
    logic [1:0] acc_track;
    logic       inflight;

    always_ff @(posedge clk) begin
        if (rst) begin
            spec_track <= 1'b0;
            acc_track  <= 2'd0;
            inflight   <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                spec_track <= req_spec;
                acc_track  <= req_acc;
            end else if (commit) begin
                spec_track <= 1'b0;
            end
            if (mem_req_valid && mem_req_ready) begin
                inflight <= 1'b1;
            end else if (mem_rsp_valid) begin
                inflight <= 1'b0;
            end
        end
    end

    assert_fault_scheme_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> cfg_hw_update);

    assert_cas_adds_only_ad_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (((mem_req_wdata & ~mem_req_cmp) & ~AD_MASK) == 64'd0)
                          && ((mem_req_wdata & mem_req_cmp) == mem_req_cmp)
                          && mem_req_wdata[BIT_A]);

    assert_no_dirty_for_read_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && acc_track != 2'd1) |-> (mem_req_wdata[BIT_D] == mem_req_cmp[BIT_D]));

    assert_no_release_inflight_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'd0) |-> !inflight);

    assert_cas_on_valid_entry_R7: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_cmp[BIT_V]);

    assert_dirty_only_committed_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_wdata[BIT_D] && !mem_req_cmp[BIT_D]) |-> !spec_track);

    assert_mem_req_held_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
                                                && $stable(mem_req_cmp) && $stable(mem_req_wdata)));

    assert_busy_excludes_req_R11: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && mem_req_valid));

    assert_rsp_single_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !req_ready) |=> req_ready);

endmodule

bind pte_ad_updater ptead_checker #(.PA_W(PA_W)) u_ptead_checker (
    .clk           (clk),
    .rst           (rst),
    .cfg_hw_update (cfg_hw_update),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_acc       (req_acc),
    .req_spec      (req_spec),
    .commit        (commit),
    .rsp_valid     (rsp_valid),
    .rsp_kind      (rsp_kind),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_cmp   (mem_req_cmp),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/pte_ad_updater_bench.sv
module pte_ad_updater_bench;

    localparam int PA_W = 56;
    localparam logic [PA_W-1:0] PADDR = 56'h0000_0000_8123_4560;
    localparam logic [63:0] F_V = 64'h01, F_R = 64'h02, F_W = 64'h04, F_X = 64'h08;
    localparam logic [63:0] F_A = 64'h40, F_D = 64'h80, F_SW = 64'h200;
    localparam logic [63:0] PPN = 64'h0000_0000_2468_0000;
    localparam logic [1:0] K_REL = 2'd0, K_FAULT = 2'd1, K_RETRY = 2'd2, K_DROP = 2'd3;
    localparam logic [1:0] A_LD = 2'd0, A_ST = 2'd1, A_FE = 2'd2, A_RS = 2'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_hw_update = 1'b1, cfg_exec_readable = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [63:0] req_pte = '0;
    logic [PA_W-1:0] req_paddr = PADDR;
    logic [1:0] req_acc = '0;
    logic req_spec = 1'b0, commit = 1'b0, squash = 1'b0;
    logic rsp_valid;
    logic [1:0] rsp_kind;
    logic mem_req_valid, mem_req_ready;
    logic [PA_W-1:0] mem_req_addr;
    logic [63:0] mem_req_cmp, mem_req_wdata;
    logic mem_rsp_valid;
    logic [63:0] mem_rsp_rdata;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pte_ad_updater #(.PA_W(PA_W), .MAX_RETRY(3)) u_pte_ad_updater (.*);

    // Memory model: one entry, compare-and-swap with a programmable latency.
    logic [63:0] mem_word;
    logic [PA_W-1:0] last_addr;
    int cas_cnt, wr_cnt, mem_lat, pend_cnt;
    logic churn, pend, pend_hit, ack_seen;
    logic [63:0] pend_data;

    assign mem_req_ready = 1'b1;

    always @(posedge clk) begin
        if (rst) begin
            mem_rsp_valid <= 1'b0;
            pend <= 1'b0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (pend) begin
                if (pend_cnt <= 1) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_rdata <= pend_data;
                    pend <= 1'b0;
                    if (pend_hit) ack_seen <= 1'b1;
                end else begin
                    pend_cnt <= pend_cnt - 1;
                end
            end
            if (mem_req_valid && mem_req_ready) begin
                cas_cnt <= cas_cnt + 1;
                last_addr <= mem_req_addr;
                pend <= 1'b1;
                pend_cnt <= mem_lat;
                pend_data <= mem_word;
                pend_hit <= (mem_word == mem_req_cmp);
                if (mem_word == mem_req_cmp) begin
                    mem_word <= mem_req_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else if (churn) begin
                    mem_word <= mem_word ^ F_SW;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic setup_mem(input logic [63:0] word, input int lat, input logic ch);
        @(negedge clk);
        mem_word = word;
        mem_lat = lat;
        churn = ch;
        cas_cnt = 0;
        wr_cnt = 0;
        ack_seen = 1'b0;
    endtask

    // Presents one request; reports whether it was released in the same cycle.
    task automatic issue(input logic [63:0] pte, input logic [1:0] acc, input logic spec,
                         output logic fast, output logic [1:0] fkind);
        @(negedge clk);
        req_valid = 1'b1;
        req_pte = pte;
        req_acc = acc;
        req_spec = spec;
        #1;
        fast = rsp_valid;
        fkind = rsp_kind;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp(output logic got, output logic [1:0] kind, output logic saw_ack);
        got = 1'b0;
        kind = 2'd0;
        saw_ack = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (!got) begin
                #1;
                if (rsp_valid) begin
                    got = 1'b1;
                    kind = rsp_kind;
                    saw_ack = ack_seen;
                end
                @(negedge clk);
            end
        end
    endtask

    task automatic pulse(input logic is_commit);
        if (is_commit) commit = 1'b1; else squash = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        squash = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check("R11 reset req_ready", {63'd0, req_ready}, 64'd1);
        check("R12 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R11 reset mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
    endtask

    task automatic t_fast_path;
        logic f; logic [1:0] k;
        setup_mem(PPN | F_V | F_R | F_W | F_A | F_D, 1, 1'b0);
        issue(PPN | F_V | F_R | F_W | F_A, A_LD, 1'b0, f, k);
        check("R1 load fast release", {61'd0, f, k}, {61'd0, 1'b1, K_REL});
        issue(PPN | F_V | F_R | F_W | F_A | F_D, A_ST, 1'b1, f, k);
        check("R1 store fast release", {61'd0, f, k}, {61'd0, 1'b1, K_REL});
        check("R1 no memory request", cas_cnt, 0);
    endtask

    task automatic expect_fault(input string tag, input logic [63:0] pte, input logic [1:0] acc);
        logic f, g, a; logic [1:0] k;
        issue(pte, acc, 1'b0, f, k);
        check({tag, " not fast"}, {63'd0, f}, 64'd0);
        wait_rsp(g, k, a);
        check(tag, {61'd0, g, k}, {61'd0, 1'b1, K_FAULT});
    endtask

    task automatic t_permissions;
        logic f; logic [1:0] k;
        setup_mem(64'd0, 1, 1'b0);
        expect_fault("R2 invalid entry", PPN | F_R | F_A, A_LD);
        expect_fault("R2 write without read", PPN | F_V | F_W | F_A | F_D, A_ST);
        expect_fault("R2 fetch without exec", PPN | F_V | F_R | F_A, A_FE);
        expect_fault("R2 store without write", PPN | F_V | F_R | F_A | F_D, A_ST);
        expect_fault("R2 reserved access code", PPN | F_V | F_R | F_W | F_X | F_A | F_D, A_RS);
        expect_fault("R2 load exec-only, option off", PPN | F_V | F_X | F_A, A_LD);
        cfg_exec_readable = 1'b1;
        issue(PPN | F_V | F_X | F_A, A_LD, 1'b0, f, k);
        check("R2 load exec-only, option on", {61'd0, f, k}, {61'd0, 1'b1, K_REL});
        cfg_exec_readable = 1'b0;
        check("R2 no memory request", cas_cnt, 0);
    endtask

    task automatic t_fault_scheme;
        cfg_hw_update = 1'b0;
        setup_mem(PPN | F_V | F_R | F_W, 1, 1'b0);
        expect_fault("R3 A clear in fault scheme", PPN | F_V | F_R | F_W, A_LD);
        expect_fault("R3 D clear in fault scheme", PPN | F_V | F_R | F_W | F_A, A_ST);
        check("R3 no memory request", cas_cnt, 0);
        check("R3 entry untouched", mem_word, PPN | F_V | F_R | F_W);
        cfg_hw_update = 1'b1;
    endtask

    task automatic t_update(input logic [1:0] acc, input logic [63:0] add, input string tag);
        logic f, g, a; logic [1:0] k;
        logic [63:0] p;
        p = PPN | F_V | F_R | F_W | F_X;
        setup_mem(p, 3, 1'b0);
        issue(p, acc, 1'b0, f, k);
        wait_rsp(g, k, a);
        check({tag, " R4 release"}, {61'd0, g, k}, {61'd0, 1'b1, K_REL});
        check({tag, " R4 written value"}, mem_word, p | add);
        check({tag, " R4 one write"}, wr_cnt, 1);
        check({tag, " R4 entry address"}, {8'd0, last_addr}, {8'd0, PADDR});
        check({tag, " R6 ack before release"}, {63'd0, a}, 64'd1);
    endtask

    task automatic t_race_invalid;
        logic f, g, a; logic [1:0] k;
        logic [63:0] p;
        p = PPN | F_V | F_R | F_W;
        setup_mem(p & ~F_V, 1, 1'b0);
        issue(p, A_LD, 1'b0, f, k);
        wait_rsp(g, k, a);
        check("R7 invalidated entry faults", {61'd0, g, k}, {61'd0, 1'b1, K_FAULT});
        check("R7 no write on invalid entry", wr_cnt, 0);
        check("R7 single attempt", cas_cnt, 1);
        check("R7 entry untouched", mem_word, p & ~F_V);
    endtask

    task automatic t_race_valid;
        logic f, g, a; logic [1:0] k;
        logic [63:0] p;
        p = PPN | F_V | F_R | F_W;
        setup_mem(p | F_SW, 2, 1'b0);
        issue(p, A_LD, 1'b0, f, k);
        wait_rsp(g, k, a);
        check("R7 changed entry then release", {61'd0, g, k}, {61'd0, 1'b1, K_REL});
        check("R7 two attempts", cas_cnt, 2);
        check("R7 fresh value kept", mem_word, p | F_SW | F_A);
        check("R6 ack before release after race", {63'd0, a}, 64'd1);
    endtask

    task automatic t_retry_limit;
        logic f, g, a; logic [1:0] k;
        logic [63:0] p;
        p = PPN | F_V | F_R | F_W;
        setup_mem(p ^ F_SW, 1, 1'b1);
        issue(p, A_ST, 1'b0, f, k);
        wait_rsp(g, k, a);
        check("R8 retry response", {61'd0, g, k}, {61'd0, 1'b1, K_RETRY});
        check("R8 attempt count", cas_cnt, 3);
        check("R8 no write", wr_cnt, 0);
        churn = 1'b0;
    endtask

    task automatic t_spec_store;
        logic f, g, a, seen; logic [1:0] k;
        logic [63:0] p;
        p = PPN | F_V | F_R | F_W | F_A;
        setup_mem(p, 1, 1'b0);
        issue(p, A_ST, 1'b1, f, k);
        seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            #1;
            if (mem_req_valid || rsp_valid) seen = 1'b1;
            @(negedge clk);
        end
        check("R9 speculative store holds", {63'd0, seen}, 64'd0);
        check("R9 no request before commit", cas_cnt, 0);
        pulse(1'b1);
        wait_rsp(g, k, a);
        check("R9 release after commit", {61'd0, g, k}, {61'd0, 1'b1, K_REL});
        check("R9 dirty written after commit", mem_word, p | F_D);
    endtask

    task automatic t_spec_load;
        logic f, g, a; logic [1:0] k;
        logic [63:0] p;
        p = PPN | F_V | F_R;
        setup_mem(p, 1, 1'b0);
        issue(p, A_LD, 1'b1, f, k);
        wait_rsp(g, k, a);
        check("R9 speculative A update", {61'd0, g, k}, {61'd0, 1'b1, K_REL});
        check("R9 A set without commit", mem_word, p | F_A);
    endtask

    task automatic t_squash_waiting;
        logic f, g, a; logic [1:0] k;
        logic [63:0] p;
        p = PPN | F_V | F_R | F_W | F_A;
        setup_mem(p, 1, 1'b0);
        issue(p, A_ST, 1'b1, f, k);
        @(negedge clk);
        @(negedge clk);
        pulse(1'b0);
        wait_rsp(g, k, a);
        check("R10 squash while waiting drops", {61'd0, g, k}, {61'd0, 1'b1, K_DROP});
        check("R10 nothing written", mem_word, p);
        check("R10 no request", cas_cnt, 0);
    endtask

    task automatic t_squash_after_write;
        logic f, g, a; logic [1:0] k;
        logic [63:0] p;
        p = PPN | F_V | F_R | F_W;
        setup_mem(p, 8, 1'b0);
        issue(p, A_LD, 1'b1, f, k);
        for (int i = 0; i < 10; i++) begin
            if (cas_cnt == 0) @(negedge clk);
        end
        pulse(1'b0);
        wait_rsp(g, k, a);
        check("R10 squash after write drops", {61'd0, g, k}, {61'd0, 1'b1, K_DROP});
        check("R10 A stays set", mem_word, p | F_A);
        check("R12 idle after response", {63'd0, req_ready}, 64'd1);
    endtask

    initial begin
        mem_word = '0; mem_lat = 1; churn = 1'b0;
        cas_cnt = 0; wr_cnt = 0; ack_seen = 1'b0; pend_cnt = 0;
        pend_hit = 1'b0; pend_data = '0; last_addr = '0; mem_rsp_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fast_path();
        t_permissions();
        t_fault_scheme();
        t_update(A_LD, F_A, "load");
        t_update(A_FE, F_A, "fetch R5");
        t_update(A_ST, F_A | F_D, "store");
        t_race_invalid();
        t_race_valid();
        t_retry_limit();
        t_spec_store();
        t_spec_load();
        t_squash_waiting();
        t_squash_after_write();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule